// File: doc/BRIEF.md
# Word-Level SEC-DED Memory Datapath with Scrubbing

This block sits between a host request port and a synchronous memory that stores 64 data bits and 8 check bits per word. Every write to memory carries a freshly computed single-error-correct, double-error-detect code over the whole 64-bit word. A host write that does not enable all eight byte lanes is turned into a read, a merge of the enabled bytes into the stored word, a fresh encode and a write back. This keeps the code valid for the full word.

On a host read, the stored word and its check bits are decoded. A 2-bit integrity mode chooses what happens next. The block can pass data through unchecked, detect and report errors without altering data, correct single-bit errors, or correct them and also write the repaired word back to the same location without host involvement. Single-bit and uncorrectable errors each raise a one-cycle pulse, and the word address of the access is presented with the pulse.

The memory has one cycle of read latency and is outside this block. Arbitration, refresh and memory timing are not handled here. The host sees a simple ready signal that stays low while a merge or repair write is in flight.

Top module: `qecc_scrub_top`

## Requirements
- R1: A host write with all eight byte enables set goes to memory in the cycle it is accepted, with the check field computed as follows. Data bit i occupies the i-th codeword position, counting from position 3 upward and skipping every power of two. Check bit j (j=0..6) is the XOR of the data bits whose position has bit j set. Check bit 7 is the XOR of all 64 data bits and check bits 0..6. The memory word is laid out as {check[7:0], data[63:0]}.
- R2: A host write with any byte enable clear is handled as a read-merge-write. Enabled lanes (lane b = data bits 8b+7..8b) come from the host and the other lanes come from the stored word. The result is written with a fresh check field two clocks after acceptance. hostReady is low for the two cycles after acceptance.
- R3: Integrity mode 00 performs no checking. Read data is returned exactly as stored and no error pulse is raised.
- R4: Integrity mode 01 detects and reports single-bit and uncorrectable errors but returns read data unmodified.
- R5: Integrity modes 10 and 11 return the corrected word when there is a single flipped bit, whether the flip is in a data bit or a check bit. In mode 10 memory is left unchanged.
- R6: In mode 11, a read that finds a single-bit error writes the corrected word with a fresh check field back to the same address in the cycle after the check. The write happens while the response is presented, and hostReady is low in that cycle, so the repair write goes ahead of the next host request.
- R7: Two flipped bits in one word raise mbeErr and never sbeErr. The two error pulses are never high together, and no repair write follows an uncorrectable error.
- R8: During a read-merge-write, an uncorrectable error in the stored word is reported with mbeErr, and the merge-write still completes using the stored bytes as read. A single-bit error in the stored word is corrected before merging in modes 10 and 11.
- R9: rspValid is a one-cycle pulse two clocks after a read is accepted. sbeErr and mbeErr pulse in that same cycle (for reads) or one cycle after the check (for merge-writes), and errAddr holds the word address of the access.
- R10: After reset, hostReady is high, and rspValid, sbeErr, mbeErr and memEn are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Integrity mode: 00 off, 01 detect, 10 correct, 11 correct and scrub |
| hostReq | input | 1 | Host request valid |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostAddr | input | ADDR_W | Word address |
| hostWdata | input | 64 | Write data |
| hostBe | input | 8 | Byte-lane enables for writes |
| hostReady | output | 1 | Request accepted when high together with hostReq |
| rspValid | output | 1 | Read data valid pulse |
| rspData | output | 64 | Read data |
| sbeErr | output | 1 | Single-bit error pulse |
| mbeErr | output | 1 | Uncorrectable error pulse |
| errAddr | output | ADDR_W | Address of the last reported error |
| memEn | output | 1 | Memory access enable |
| memWe | output | 1 | Memory write enable |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | 64 | Memory write data |
| memWcheck | output | 8 | Memory write check bits |
| memRdata | input | 64 | Memory read data, one cycle after the read |
| memRcheck | input | 8 | Memory read check bits, one cycle after the read |

## Verification
The bench builds the block with ADDR_W set to 4. This gives a 16-word memory, so the top word address and every error-address value can be reached with a few directed accesses. Because the memory array lives in the bench, bits can be flipped directly in stored words, in data and in check positions. The stored word can then be compared against an independently computed encoding after repair writes and merge-writes, in every integrity mode.

// File: rtl/qecc_pkg.sv
package qecc_pkg;

  localparam int DATA_W = 64;
  localparam int HAM_W  = 7;
  localparam int CHK_W  = HAM_W + 1;
  localparam int LANES  = DATA_W / 8;

  typedef logic [HAM_W-1:0] pos_t;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_DETECT  = 2'b01,
    MODE_CORRECT = 2'b10,
    MODE_SCRUB   = 2'b11
  } integrity_e;

  typedef struct packed {
    logic capture;   // latch the host request
    logic evaluate;  // decoded memory word is on the read bus
    logic opRead;    // the latched request is a read
    logic wbSel;     // memory port driven from the write-back register
  } ctlStrobe_t;

  // codeword position of data bit idx: non-power-of-two positions from 3 upward
  function automatic pos_t dataPos(int idx);
    int seen;
    pos_t r;
    seen = 0;
    r = '0;
    for (int p = 3; p < (1 << HAM_W); p++) begin
      if ((p & (p - 1)) != 0) begin
        if (seen == idx) r = pos_t'(p);
        seen++;
      end
    end
    return r;
  endfunction

  // data bits covered by check bit j
  function automatic logic [DATA_W-1:0] colMask(int j);
    logic [DATA_W-1:0] m;
    pos_t p;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      p = dataPos(i);
      m[i] = p[j];
    end
    return m;
  endfunction

endpackage

// File: rtl/qecc_hamming.sv
module qecc_hamming
  import qecc_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [HAM_W-1:0]  ham
);
  for (genvar j = 0; j < HAM_W; j++) begin : g_col
    localparam logic [DATA_W-1:0] MASK = colMask(j);
    assign ham[j] = ^(data & MASK);
  end
endmodule

// File: rtl/qecc_decoder.sv
module qecc_decoder
  import qecc_pkg::*;
(
  input  logic [DATA_W-1:0] rdata,
  input  logic [CHK_W-1:0]  rcheck,
  output logic [DATA_W-1:0] corrData,
  output logic              single,
  output logic              multi
);
  logic [HAM_W-1:0]  recomputed;
  pos_t              synd;
  logic              parOdd;
  logic [DATA_W-1:0] hit;
  logic              anyHit;
  logic              checkPos;
  logic              syndZero;

  qecc_hamming u_ham (.data(rdata), .ham(recomputed));

  assign synd   = recomputed ^ rcheck[HAM_W-1:0];
  assign parOdd = ^{rdata, rcheck};

  for (genvar i = 0; i < DATA_W; i++) begin : g_hit
    localparam pos_t POS = dataPos(i);
    assign hit[i] = (synd == POS);
  end

  assign anyHit   = |hit;
  assign syndZero = (synd == '0);
  assign checkPos = !syndZero && ((synd & (synd - 1'b1)) == '0);

  always_comb begin
    single   = parOdd && (syndZero || anyHit || checkPos);
    multi    = (!parOdd && !syndZero) || (parOdd && !(syndZero || anyHit || checkPos));
    corrData = parOdd ? (rdata ^ hit) : rdata;
  end
endmodule

// File: rtl/qecc_control.sv
module qecc_control
  import qecc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hostReq,
  input  logic       hostWe,
  input  logic       hostBeFull,
  input  logic       needScrub,
  output logic       hostReady,
  output logic       memEn,
  output logic       memWe,
  output ctlStrobe_t strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_WRBACK} state_e;

  state_e stateQ, stateD;
  logic   opReadQ;

  always_comb begin
    stateD          = stateQ;
    hostReady       = 1'b0;
    memEn           = 1'b0;
    memWe           = 1'b0;
    strobe          = '0;
    strobe.opRead   = opReadQ;
    unique case (stateQ)
      ST_IDLE: begin
        hostReady = 1'b1;
        if (hostReq) begin
          strobe.capture = 1'b1;
          memEn          = 1'b1;
          memWe          = hostWe && hostBeFull;
          if (!(hostWe && hostBeFull)) stateD = ST_CHECK;
        end
      end
      ST_CHECK: begin
        strobe.evaluate = 1'b1;
        stateD = (!opReadQ || needScrub) ? ST_WRBACK : ST_IDLE;
      end
      ST_WRBACK: begin
        memEn        = 1'b1;
        memWe        = 1'b1;
        strobe.wbSel = 1'b1;
        stateD       = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ  <= ST_IDLE;
      opReadQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (strobe.capture) opReadQ <= !hostWe;
    end
  end
endmodule

// File: rtl/qecc_datapath.sv
module qecc_datapath
  import qecc_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        strobe,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [LANES-1:0]  hostBe,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [CHK_W-1:0]  memRcheck,
  output logic              needScrub,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              sbeErr,
  output logic              mbeErr,
  output logic [ADDR_W-1:0] errAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [CHK_W-1:0]  memWcheck
);
  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqData;
  logic [LANES-1:0]  reqBe;
  logic [DATA_W-1:0] wbData;

  logic [DATA_W-1:0] corrData;
  logic              decSingle, decMulti;
  logic              checkOn, correctOn;
  logic [DATA_W-1:0] srcWord;
  logic [DATA_W-1:0] merged;
  logic [HAM_W-1:0]  outHam;

  qecc_decoder u_dec (
    .rdata   (memRdata),
    .rcheck  (memRcheck),
    .corrData(corrData),
    .single  (decSingle),
    .multi   (decMulti)
  );

  assign checkOn   = (mode != MODE_OFF);
  assign correctOn = mode[1];
  assign srcWord   = (correctOn && decSingle) ? corrData : memRdata;
  assign needScrub = (mode == MODE_SCRUB) && decSingle;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign merged[8*b +: 8] = reqBe[b] ? reqData[8*b +: 8] : srcWord[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reqAddr  <= '0;
      reqData  <= '0;
      reqBe    <= '0;
      wbData   <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
      sbeErr   <= 1'b0;
      mbeErr   <= 1'b0;
      errAddr  <= '0;
    end else begin
      rspValid <= strobe.evaluate && strobe.opRead;
      sbeErr   <= strobe.evaluate && checkOn && decSingle;
      mbeErr   <= strobe.evaluate && checkOn && decMulti;
      if (strobe.capture) begin
        reqAddr <= hostAddr;
        reqData <= hostWdata;
        reqBe   <= hostBe;
      end
      if (strobe.evaluate) begin
        if (strobe.opRead) rspData <= srcWord;
        wbData <= strobe.opRead ? corrData : merged;
        if (checkOn && (decSingle || decMulti)) errAddr <= reqAddr;
      end
    end
  end

  assign memAddr  = strobe.wbSel ? reqAddr : hostAddr;
  assign memWdata = strobe.wbSel ? wbData : hostWdata;

  qecc_hamming u_enc (.data(memWdata), .ham(outHam));

  assign memWcheck = {^{memWdata, outHam}, outHam};
endmodule

// File: rtl/qecc_scrub_top.sv
module qecc_scrub_top
  import qecc_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [63:0]       hostWdata,
  input  logic [7:0]        hostBe,
  output logic              hostReady,
  output logic              rspValid,
  output logic [63:0]       rspData,
  output logic              sbeErr,
  output logic              mbeErr,
  output logic [ADDR_W-1:0] errAddr,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [63:0]       memWdata,
  output logic [7:0]        memWcheck,
  input  logic [63:0]       memRdata,
  input  logic [7:0]        memRcheck
);
  ctlStrobe_t strobe;
  logic       needScrub;

  qecc_control u_ctl (
    .clk       (clk),
    .rst       (rst),
    .hostReq   (hostReq),
    .hostWe    (hostWe),
    .hostBeFull(&hostBe),
    .needScrub (needScrub),
    .hostReady (hostReady),
    .memEn     (memEn),
    .memWe     (memWe),
    .strobe    (strobe)
  );

  qecc_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .mode     (mode),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .hostBe   (hostBe),
    .memRdata (memRdata),
    .memRcheck(memRcheck),
    .needScrub(needScrub),
    .rspValid (rspValid),
    .rspData  (rspData),
    .sbeErr   (sbeErr),
    .mbeErr   (mbeErr),
    .errAddr  (errAddr),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memWcheck(memWcheck)
  );
endmodule

// File: rtl/qecc_checker.sv
module qecc_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic       hostReady,
  input logic       rspValid,
  input logic       sbeErr,
  input logic       mbeErr,
  input logic       memEn,
  input logic       memWe
);
  AST_ONE_ERR_KIND: assert property (@(posedge clk) disable iff (rst)
    !(sbeErr && mbeErr)); // R7
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> !rspValid); // R9
  AST_SBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    sbeErr |=> !sbeErr); // R9
  AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    memWe |-> memEn); // R1
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == 2'b00) |-> (!sbeErr && !mbeErr)); // R3
  AST_SCRUB_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (rspValid && sbeErr && $past(mode) == 2'b11) |-> (memWe && !hostReady)); // R6
  AST_NO_WB_WITHOUT_SCRUB: assert property (@(posedge clk) disable iff (rst)
    (rspValid && $past(mode) != 2'b11) |-> !memWe); // R5
  AST_BUSY_ONLY_WRITES: assert property (@(posedge clk) disable iff (rst)
    (!hostReady && memEn) |-> memWe); // R2
endmodule

bind qecc_scrub_top qecc_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode     (mode),
  .hostReady(hostReady),
  .rspValid (rspValid),
  .sbeErr   (sbeErr),
  .mbeErr   (mbeErr),
  .memEn    (memEn),
  .memWe    (memWe)
);

// File: tb/qecc_scrub_top_bench.sv
`timescale 1ns/1ps
module qecc_scrub_top_bench;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode = 2'b10;
  logic          hostReq = 1'b0;
  logic          hostWe = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [63:0]   hostWdata = '0;
  logic [7:0]    hostBe = '0;
  logic          hostReady, rspValid, sbeErr, mbeErr, memEn, memWe;
  logic [63:0]   rspData, memWdata, memRdata;
  logic [AW-1:0] errAddr, memAddr;
  logic [7:0]    memWcheck, memRcheck;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [71:0] mem [1 << AW];
  logic [71:0] rdQ;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) mem[memAddr] <= {memWcheck, memWdata};
      else rdQ <= mem[memAddr];
    end
  end
  assign memRdata  = rdQ[63:0];
  assign memRcheck = rdQ[71:64];

  qecc_scrub_top #(.ADDR_W(AW)) u_qecc_scrub_top (
    .clk(clk), .rst(rst), .mode(mode), .hostReq(hostReq), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostBe(hostBe),
    .hostReady(hostReady), .rspValid(rspValid), .rspData(rspData),
    .sbeErr(sbeErr), .mbeErr(mbeErr), .errAddr(errAddr),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memWcheck(memWcheck), .memRdata(memRdata), .memRcheck(memRcheck)
  );

  // stored-word encoding as written in R1
  function automatic logic [71:0] refWord(logic [63:0] d);
    logic [6:0] h = '0;
    int idx = 0;
    for (int p = 3; p < 128 && idx < 64; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int j = 0; j < 7; j++) if (((p >> j) & 1) == 1) h[j] = h[j] ^ d[idx];
        idx++;
      end
    end
    return {(^d) ^ (^h), h, d};
  endfunction

  function automatic logic [63:0] mergeBytes(logic [63:0] oldW, logic [63:0] newW, logic [7:0] be);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = be[b] ? newW[8*b +: 8] : oldW[8*b +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic we, input logic [AW-1:0] a,
                       input logic [63:0] d, input logic [7:0] be);
    @(negedge clk);
    hostReq = 1'b1; hostWe = we; hostAddr = a; hostWdata = d; hostBe = be;
    @(posedge clk);
    @(negedge clk);
    hostReq = 1'b0;
  endtask

  task automatic fullWrite(input logic [AW-1:0] a, input logic [63:0] d);
    issue(1'b1, a, d, 8'hFF);
    chk(mem[a] == refWord(d), "R1", "stored word", mem[a], refWord(d));
    chk(hostReady == 1'b1, "R1", "ready after full write", 72'(hostReady), 72'd1);
  endtask

  // read; returns sampled outputs of the response cycle
  task automatic readOp(input logic [AW-1:0] a, output logic [63:0] rd,
                        output logic sb, output logic mb, output logic [AW-1:0] ea,
                        output logic we, output logic rdy);
    issue(1'b0, a, 64'd0, 8'h00);
    chk(rspValid == 1'b0, "R9", "no response one cycle after accept", 72'(rspValid), 72'd0);
    @(negedge clk);
    chk(rspValid == 1'b1, "R9", "response two cycles after accept", 72'(rspValid), 72'd1);
    rd = rspData; sb = sbeErr; mb = mbeErr; ea = errAddr; we = memWe; rdy = hostReady;
    @(negedge clk);
    chk(rspValid == 1'b0, "R9", "response is one cycle", 72'(rspValid), 72'd0);
  endtask

  task automatic t_reset();
    chk(hostReady == 1'b1, "R10", "ready", 72'(hostReady), 72'd1);
    chk(rspValid == 1'b0 && sbeErr == 1'b0 && mbeErr == 1'b0 && memEn == 1'b0,
        "R10", "idle outputs", 72'({rspValid, sbeErr, mbeErr, memEn}), 72'd0);
  endtask

  task automatic t_cleanRead();
    logic [63:0] rd; logic sb, mb, we, rdy; logic [AW-1:0] ea;
    mode = 2'b10;
    fullWrite(4'd3, 64'h0123_4567_89AB_CDEF);
    fullWrite(4'd15, 64'hFFFF_0000_A5A5_5A5A);
    readOp(4'd3, rd, sb, mb, ea, we, rdy);
    chk(rd == 64'h0123_4567_89AB_CDEF, "R5", "clean read data", 72'(rd), 72'h0123_4567_89AB_CDEF);
    chk(!sb && !mb, "R5", "clean read no error", 72'({sb, mb}), 72'd0);
    readOp(4'd15, rd, sb, mb, ea, we, rdy);
    chk(rd == 64'hFFFF_0000_A5A5_5A5A, "R9", "top address read", 72'(rd), 72'hFFFF_0000_A5A5_5A5A);
  endtask

  task automatic t_correctNoScrub();
    logic [63:0] rd; logic sb, mb, we, rdy; logic [AW-1:0] ea;
    logic [71:0] bad;
    mode = 2'b10;
    fullWrite(4'd4, 64'hDEAD_BEEF_CAFE_F00D);
    @(negedge clk);
    mem[4][17] = ~mem[4][17];
    bad = mem[4];
    readOp(4'd4, rd, sb, mb, ea, we, rdy);
    chk(rd == 64'hDEAD_BEEF_CAFE_F00D, "R5", "corrected data", 72'(rd), 72'hDEAD_BEEF_CAFE_F00D);
    chk(sb && !mb, "R9", "single pulse", 72'({sb, mb}), 72'b10);
    chk(ea == 4'd4, "R9", "error address", 72'(ea), 72'd4);
    chk(!we, "R5", "no write-back in mode 10", 72'(we), 72'd0);
    chk(mem[4] == bad, "R5", "memory untouched", mem[4], bad);
  endtask

  task automatic t_scrub();
    logic [63:0] rd; logic sb, mb, we, rdy; logic [AW-1:0] ea;
    mode = 2'b11;
    fullWrite(4'd5, 64'h1111_2222_3333_4444);
    @(negedge clk);
    mem[5][40] = ~mem[5][40];
    readOp(4'd5, rd, sb, mb, ea, we, rdy);
    chk(rd == 64'h1111_2222_3333_4444, "R6", "scrub read data", 72'(rd), 72'h1111_2222_3333_4444);
    chk(sb && we && !rdy, "R6", "write-back with host held", 72'({sb, we, rdy}), 72'b110);
    chk(mem[5] == refWord(64'h1111_2222_3333_4444), "R6", "word repaired", mem[5],
        refWord(64'h1111_2222_3333_4444));
    // check-bit flip (stored bit 66 = check bit 2)
    fullWrite(4'd6, 64'h0F0F_0F0F_0F0F_0F0F);
    @(negedge clk);
    mem[6][66] = ~mem[6][66];
    readOp(4'd6, rd, sb, mb, ea, we, rdy);
    chk(rd == 64'h0F0F_0F0F_0F0F_0F0F && sb && !mb, "R5", "check-bit flip", 72'({sb, mb, rd}),
        72'({1'b1, 1'b0, 64'h0F0F_0F0F_0F0F_0F0F}));
    chk(mem[6] == refWord(64'h0F0F_0F0F_0F0F_0F0F), "R6", "check bit repaired", mem[6],
        refWord(64'h0F0F_0F0F_0F0F_0F0F));
    // double in scrub mode: no repair write
    fullWrite(4'd9, 64'h7777_8888_9999_AAAA);
    @(negedge clk);
    mem[9][3] = ~mem[9][3]; mem[9][50] = ~mem[9][50];
    readOp(4'd9, rd, sb, mb, ea, we, rdy);
    chk(!sb && mb && !we, "R7", "double in mode 11", 72'({sb, mb, we}), 72'b010);
  endtask

  task automatic t_detect();
    logic [63:0] rd; logic sb, mb, we, rdy; logic [AW-1:0] ea;
    mode = 2'b01;
    fullWrite(4'd7, 64'hAAAA_BBBB_CCCC_DDDD);
    @(negedge clk);
    mem[7][0] = ~mem[7][0];
    readOp(4'd7, rd, sb, mb, ea, we, rdy);
    chk(rd == 64'hAAAA_BBBB_CCCC_DDDC, "R4", "raw data returned", 72'(rd), 72'hAAAA_BBBB_CCCC_DDDC);
    chk(sb && !mb && ea == 4'd7, "R4", "single detected", 72'({sb, mb, ea}), 72'({1'b1, 1'b0, 4'd7}));
    @(negedge clk);
    mem[7][63] = ~mem[7][63];
    readOp(4'd7, rd, sb, mb, ea, we, rdy);
    chk(!sb && mb, "R7", "double detected in mode 01", 72'({sb, mb}), 72'b01);
  endtask

  task automatic t_double();
    logic [63:0] rd; logic sb, mb, we, rdy; logic [AW-1:0] ea;
    mode = 2'b10;
    fullWrite(4'd10, 64'h5555_6666_7777_8888);
    @(negedge clk);
    mem[10][12] = ~mem[10][12]; mem[10][13] = ~mem[10][13];
    readOp(4'd10, rd, sb, mb, ea, we, rdy);
    chk(!sb && mb && !we, "R7", "double in mode 10", 72'({sb, mb, we}), 72'b010);
    chk(ea == 4'd10, "R9", "double error address", 72'(ea), 72'd10);
  endtask

  task automatic t_off();
    logic [63:0] rd; logic sb, mb, we, rdy; logic [AW-1:0] ea;
    mode = 2'b00;
    fullWrite(4'd11, 64'h0000_0000_FFFF_FFFF);
    @(negedge clk);
    mem[11][8] = ~mem[11][8];
    readOp(4'd11, rd, sb, mb, ea, we, rdy);
    chk(rd == 64'h0000_0000_FFFF_FEFF, "R3", "raw data with checking off", 72'(rd),
        72'h0000_0000_FFFF_FEFF);
    chk(!sb && !mb, "R3", "no pulses with checking off", 72'({sb, mb}), 72'd0);
  endtask

  task automatic partial(input logic [AW-1:0] a, input logic [63:0] newD, input logic [7:0] be,
                         output logic sb, output logic mb);
    issue(1'b1, a, newD, be);
    chk(hostReady == 1'b0, "R2", "busy during merge", 72'(hostReady), 72'd0);
    @(negedge clk);
    sb = sbeErr; mb = mbeErr;
    chk(hostReady == 1'b0 && memWe == 1'b1, "R2", "merge write cycle", 72'({hostReady, memWe}), 72'b01);
    @(negedge clk);
    chk(hostReady == 1'b1, "R2", "ready after merge", 72'(hostReady), 72'd1);
  endtask

  task automatic t_partial();
    logic sb, mb;
    logic [63:0] oldD, newD, exp, rawOld;
    mode = 2'b10;
    oldD = 64'h8899_AABB_CCDD_EEFF;
    newD = 64'h1020_3040_5060_7080;
    fullWrite(4'd8, oldD);
    partial(4'd8, newD, 8'h0F, sb, mb);
    exp = mergeBytes(oldD, newD, 8'h0F);
    chk(mem[8] == refWord(exp), "R2", "clean merge", mem[8], refWord(exp));
    chk(!sb && !mb, "R2", "clean merge no error", 72'({sb, mb}), 72'd0);
    // single error in a kept byte is corrected before merging
    fullWrite(4'd12, oldD);
    @(negedge clk);
    mem[12][60] = ~mem[12][60];
    partial(4'd12, newD, 8'h0F, sb, mb);
    chk(mem[12] == refWord(exp), "R8", "merge with corrected old", mem[12], refWord(exp));
    chk(sb && !mb, "R8", "single reported on merge", 72'({sb, mb}), 72'b10);
    // uncorrectable old word: write completes with stored bytes, error reported
    fullWrite(4'd13, oldD);
    @(negedge clk);
    mem[13][60] = ~mem[13][60]; mem[13][61] = ~mem[13][61];
    rawOld = oldD ^ (64'h3 << 60);
    partial(4'd13, newD, 8'hF0, sb, mb);
    exp = mergeBytes(rawOld, newD, 8'hF0);
    chk(mem[13] == refWord(exp), "R8", "merge completes on double", mem[13], refWord(exp));
    chk(!sb && mb && errAddr == 4'd13, "R8", "double reported on merge",
        72'({sb, mb, errAddr}), 72'({1'b0, 1'b1, 4'd13}));
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = refWord(64'd0);
    rdQ = refWord(64'd0);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cleanRead();
    t_correctNoScrub();
    t_scrub();
    t_detect();
    t_double();
    t_off();
    t_partial();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule